// File: doc/BRIEF.md
# Scale-Space Extremum Detector

This block finds candidate keypoints in a scale-space stack. Each valid cycle it receives four 3x3 windows taken at the same image position from four blurred images of one octave. The windows are ordered from the least blurred to the most blurred. Adjacent pairs are subtracted with saturation to form three difference planes, called lower, middle and upper. The centre sample of the middle plane is then compared with all 26 samples around it: the 8 surrounding samples in its own plane and all 9 samples in each of the other two planes.

Each of the 26 parallel comparators emits a 2-bit code. A reduction stage turns the 26 codes into a verdict: strict maximum, strict minimum, or no candidate. The verdict is registered and leaves the block two cycles after the input. It is tagged with a valid strobe and the row, column and scale index of the centre sample. A scheduler sweeps the three searchable scale levels of each octave through the block, one window per cycle.

Top module: `scale_extrema_finder`

## Requirements
- R1: Difference plane k (k = 0 lower, 1 middle, 2 upper) is formed sample by sample as blur window k+1 minus blur window k, each sample signed two's-complement of DW bits. Sample (r,c) of a window sits at bits [(3r+c)*DW +: DW], and the centre is index 4.
- R2: A difference that exceeds the signed DW-bit range is clamped to the largest positive or the most negative value. It never wraps.
- R3: When the middle-plane centre is strictly greater than all 26 neighbours, the result is out_cand=1 and out_is_max=1.
- R4: When the middle-plane centre is strictly less than all 26 neighbours, the result is out_cand=1 and out_is_max=0.
- R5: If any neighbour in any of the three planes equals the centre, the sample is not a candidate (out_cand=0). A flat neighbourhood is never a candidate.
- R6: A single neighbour on the wrong side, in any plane, removes the candidate: one larger neighbour blocks a maximum, and one smaller neighbour blocks a minimum.
- R7: out_valid follows in_valid exactly two clock cycles later. out_row, out_col and out_scale carry that input's coordinates. A new window may be accepted on every cycle.
- R8: After the synchronous active-high reset, and whenever out_valid is 0, out_cand and out_is_max are 0. out_is_max is 1 only together with out_cand.
- R9: Each comparator code is 00 when the centre equals the neighbour, 01 when the centre is greater, and 10 when it is less. Code 11 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input windows and coordinates are valid this cycle |
| in_row | input | ROW_W (12) | Row of the centre sample |
| in_col | input | COL_W (12) | Column of the centre sample |
| in_scale | input | SCALE_W (3) | Scale index of the middle plane |
| blur_l0 | input | 9*DW (144) | 3x3 window of the least blurred image |
| blur_l1 | input | 9*DW (144) | 3x3 window of the next blur level |
| blur_l2 | input | 9*DW (144) | 3x3 window of the next blur level |
| blur_l3 | input | 9*DW (144) | 3x3 window of the most blurred image |
| out_valid | output | 1 | Result valid, two cycles after in_valid |
| out_cand | output | 1 | Centre is a strict 26-neighbour extremum |
| out_is_max | output | 1 | 1 for maximum, 0 for minimum (meaningful with out_cand) |
| out_row | output | ROW_W (12) | Row of the reported sample |
| out_col | output | COL_W (12) | Column of the reported sample |
| out_scale | output | SCALE_W (3) | Scale index of the reported sample |

## Verification
Subtraction clamping and tie rejection can decide the same verdict in one cycle. This happens when the centre difference and one neighbour difference both overflow toward the same limit and end up equal after clamping. The bench provokes this with blur windows whose centre and one same-plane neighbour both span the full signed range. It judges the result as "no candidate". The same window without the second overflow must still report a maximum, and a wrapping subtractor would have reported neither. Back-to-back windows with distinct coordinates also check that a verdict and its coordinates never drift apart in the two-stage pipeline.

// File: rtl/sxf_pkg.sv
package sxf_pkg;

    // Geometry of the search neighbourhood
    localparam int WIN          = 3;
    localparam int WIN_N        = WIN * WIN;
    localparam int N_PLANES     = 3;
    localparam int N_BLUR       = N_PLANES + 1;
    localparam int CENTRE_IDX   = WIN_N / 2;
    localparam int STACK_CENTRE = WIN_N + CENTRE_IDX;
    localparam int N_NEIGH      = N_PLANES * WIN_N - 1;

    // Outcome of one two-input comparison, seen from the centre sample
    typedef enum logic [1:0] {
        CMP_EQ = 2'b00,
        CMP_GT = 2'b01,
        CMP_LT = 2'b10
    } cmp_code_e;

    // Reduced decision over all neighbours
    typedef struct packed {
        logic hit;
        logic is_max;
    } verdict_t;

    // Comparator slot of sample idx in plane p; the stack centre has no slot
    function automatic int slot_of(int p, int idx);
        int g;
        g = p * WIN_N + idx;
        return (g > STACK_CENTRE) ? g - 1 : g;
    endfunction

endpackage

// File: rtl/sxf_plane_sub.sv
module sxf_plane_sub
    import sxf_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [WIN_N*DW-1:0] finer,
    input  logic [WIN_N*DW-1:0] coarser,
    output logic [WIN_N*DW-1:0] diff
);

    localparam logic [DW-1:0] POS_LIMIT = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] NEG_LIMIT = {1'b1, {(DW-1){1'b0}}};

    function automatic logic [DW-1:0] clamp(logic [DW:0] wide);
        if (wide[DW] != wide[DW-1])
            return wide[DW] ? NEG_LIMIT : POS_LIMIT;
        return wide[DW-1:0];
    endfunction

    for (genvar i = 0; i < WIN_N; i++) begin : g_samp
        logic signed [DW:0] hi_ext;
        logic signed [DW:0] lo_ext;
        logic signed [DW:0] wide;
        assign hi_ext = {coarser[i*DW+DW-1], coarser[i*DW +: DW]};
        assign lo_ext = {finer[i*DW+DW-1], finer[i*DW +: DW]};
        assign wide   = hi_ext - lo_ext;
        assign diff[i*DW +: DW] = clamp(wide);
    end

endmodule

// File: rtl/sxf_cmp.sv
module sxf_cmp
    import sxf_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic signed [DW-1:0] centre,
    input  logic signed [DW-1:0] other,
    output cmp_code_e            code
);

    always_comb begin
        if (centre > other)
            code = CMP_GT;
        else if (centre < other)
            code = CMP_LT;
        else
            code = CMP_EQ;
    end

endmodule

// File: rtl/sxf_reduce.sv
module sxf_reduce
    import sxf_pkg::*;
#(
    parameter int N = N_NEIGH
) (
    input  cmp_code_e codes [N],
    output verdict_t  verdict
);

    logic [N-1:0] above_all;
    logic [N-1:0] below_all;

    for (genvar n = 0; n < N; n++) begin : g_bit
        assign above_all[n] = (codes[n] == CMP_GT);
        assign below_all[n] = (codes[n] == CMP_LT);
    end

    always_comb begin
        verdict.is_max = &above_all;
        verdict.hit    = (&above_all) | (&below_all);
    end

endmodule

// File: rtl/scale_extrema_finder.sv
module scale_extrema_finder
    import sxf_pkg::*;
#(
    parameter int DW      = 16,
    parameter int ROW_W   = 12,
    parameter int COL_W   = 12,
    parameter int SCALE_W = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [ROW_W-1:0]      in_row,
    input  logic [COL_W-1:0]      in_col,
    input  logic [SCALE_W-1:0]    in_scale,
    input  logic [WIN_N*DW-1:0]   blur_l0,
    input  logic [WIN_N*DW-1:0]   blur_l1,
    input  logic [WIN_N*DW-1:0]   blur_l2,
    input  logic [WIN_N*DW-1:0]   blur_l3,
    output logic                  out_valid,
    output logic                  out_cand,
    output logic                  out_is_max,
    output logic [ROW_W-1:0]      out_row,
    output logic [COL_W-1:0]      out_col,
    output logic [SCALE_W-1:0]    out_scale
);

    localparam int PLANE_W = WIN_N * DW;

    // ---------------- stage 1: difference planes ----------------
    logic [PLANE_W-1:0] blur   [N_BLUR];
    logic [PLANE_W-1:0] diff_c [N_PLANES];
    logic [PLANE_W-1:0] diff_q [N_PLANES];

    assign blur[0] = blur_l0;
    assign blur[1] = blur_l1;
    assign blur[2] = blur_l2;
    assign blur[3] = blur_l3;

    for (genvar p = 0; p < N_PLANES; p++) begin : g_sub
        sxf_plane_sub #(.DW(DW)) u_sub (
            .finer   (blur[p]),
            .coarser (blur[p+1]),
            .diff    (diff_c[p])
        );
    end

    logic               s1_valid;
    logic [ROW_W-1:0]   s1_row;
    logic [COL_W-1:0]   s1_col;
    logic [SCALE_W-1:0] s1_scale;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_row   <= '0;
            s1_col   <= '0;
            s1_scale <= '0;
            for (int p = 0; p < N_PLANES; p++)
                diff_q[p] <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_row   <= in_row;
            s1_col   <= in_col;
            s1_scale <= in_scale;
            for (int p = 0; p < N_PLANES; p++)
                diff_q[p] <= diff_c[p];
        end
    end

    // ---------------- stage 2: compare and reduce ----------------
    logic [DW-1:0] centre;
    assign centre = diff_q[1][CENTRE_IDX*DW +: DW];

    cmp_code_e codes [N_NEIGH];

    for (genvar p = 0; p < N_PLANES; p++) begin : g_plane
        for (genvar i = 0; i < WIN_N; i++) begin : g_pos
            if (!(p == 1 && i == CENTRE_IDX)) begin : g_cmp
                localparam int SLOT = slot_of(p, i);
                sxf_cmp #(.DW(DW)) u_cmp (
                    .centre (centre),
                    .other  (diff_q[p][i*DW +: DW]),
                    .code   (codes[SLOT])
                );
            end
        end
    end

    // flattened view of the codes, observed by the bound checker
    logic [2*N_NEIGH-1:0] cmp_codes;
    always_comb begin
        for (int n = 0; n < N_NEIGH; n++)
            cmp_codes[2*n +: 2] = codes[n];
    end

    verdict_t verdict;

    sxf_reduce #(.N(N_NEIGH)) u_reduce (
        .codes   (codes),
        .verdict (verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_cand   <= 1'b0;
            out_is_max <= 1'b0;
            out_row    <= '0;
            out_col    <= '0;
            out_scale  <= '0;
        end else begin
            out_valid  <= s1_valid;
            out_cand   <= s1_valid & verdict.hit;
            out_is_max <= s1_valid & verdict.hit & verdict.is_max;
            out_row    <= s1_row;
            out_col    <= s1_col;
            out_scale  <= s1_scale;
        end
    end

endmodule

// File: rtl/sxf_extrema_chk.sv
module sxf_extrema_chk
    import sxf_pkg::*;
#(
    parameter int N = N_NEIGH
) (
    input logic           clk,
    input logic           rst,
    input logic           in_valid,
    input logic           out_valid,
    input logic           out_cand,
    input logic           out_is_max,
    input logic [2*N-1:0] codes
);

    logic [1:0] cyc;
    always_ff @(posedge clk) begin
        if (rst)
            cyc <= '0;
        else if (cyc != 2'd2)
            cyc <= cyc + 2'd1;
    end

    int n_gt, n_lt, n_eq, n_bad;
    always_comb begin
        n_gt = 0; n_lt = 0; n_eq = 0; n_bad = 0;
        for (int n = 0; n < N; n++) begin
            case (codes[2*n +: 2])
                2'b00:   n_eq++;
                2'b01:   n_gt++;
                2'b10:   n_lt++;
                default: n_bad++;
            endcase
        end
    end

    assert_two_cycle_latency_R7: assert property (@(posedge clk) disable iff (rst)
        (cyc == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    assert_quiet_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!out_cand && !out_is_max));

    assert_max_implies_cand_R8: assert property (@(posedge clk) disable iff (rst)
        out_is_max |-> out_cand);

    assert_code_legal_R9: assert property (@(posedge clk) disable iff (rst)
        n_bad == 0);

    assert_max_all_greater_R3: assert property (@(posedge clk) disable iff (rst)
        (cyc != 2'd0 && out_cand && out_is_max) |-> ($past(n_gt) == N));

    assert_min_all_less_R4: assert property (@(posedge clk) disable iff (rst)
        (cyc != 2'd0 && out_cand && !out_is_max) |-> ($past(n_lt) == N));

    assert_tie_blocks_R5: assert property (@(posedge clk) disable iff (rst)
        (cyc != 2'd0 && $past(n_eq) != 0) |-> !out_cand);

endmodule

bind scale_extrema_finder sxf_extrema_chk #(.N(sxf_pkg::N_NEIGH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .out_valid  (out_valid),
    .out_cand   (out_cand),
    .out_is_max (out_is_max),
    .codes      (cmp_codes)
);

// File: tb/scale_extrema_finder_test.sv
module scale_extrema_finder_test;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 16;
    localparam int ROW_W      = 12;
    localparam int COL_W      = 12;
    localparam int SCALE_W    = 3;
    localparam int NS         = 9;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic               rst;
    logic               in_valid;
    logic [ROW_W-1:0]   in_row;
    logic [COL_W-1:0]   in_col;
    logic [SCALE_W-1:0] in_scale;
    logic [NS*DW-1:0]   blur_vec [4];
    logic               out_valid, out_cand, out_is_max;
    logic [ROW_W-1:0]   out_row;
    logic [COL_W-1:0]   out_col;
    logic [SCALE_W-1:0] out_scale;

    logic signed [DW-1:0] bw [4][NS];
    int dlo [NS];
    int dmid [NS];
    int dhi [NS];

    always_comb begin
        for (int k = 0; k < 4; k++)
            for (int i = 0; i < NS; i++)
                blur_vec[k][i*DW +: DW] = bw[k][i];
    end

    scale_extrema_finder #(.DW(DW), .ROW_W(ROW_W), .COL_W(COL_W), .SCALE_W(SCALE_W)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_row(in_row), .in_col(in_col), .in_scale(in_scale),
        .blur_l0(blur_vec[0]), .blur_l1(blur_vec[1]),
        .blur_l2(blur_vec[2]), .blur_l3(blur_vec[3]),
        .out_valid(out_valid), .out_cand(out_cand), .out_is_max(out_is_max),
        .out_row(out_row), .out_col(out_col), .out_scale(out_scale)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    task automatic chk(string req, string what, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // blur windows from wanted difference planes, on a non-flat base image
    task automatic build_from_diffs();
        for (int i = 0; i < NS; i++) begin
            bw[0][i] = DW'(11*i - 40);
            bw[1][i] = DW'(11*i - 40 + dlo[i]);
            bw[2][i] = DW'(11*i - 40 + dlo[i] + dmid[i]);
            bw[3][i] = DW'(11*i - 40 + dlo[i] + dmid[i] + dhi[i]);
        end
    endtask

    // kind 0: maximum, 1: minimum, 2: flat
    task automatic load_pattern(int kind);
        for (int i = 0; i < NS; i++) begin
            case (kind)
                0: begin dlo[i] = i - 9;  dmid[i] = i;      dhi[i] = 2*i - 3; end
                1: begin dlo[i] = 9 - i;  dmid[i] = -i;     dhi[i] = 3 - 2*i; end
                default: begin dlo[i] = 4; dmid[i] = 4;    dhi[i] = 4; end
            endcase
        end
        if (kind == 0) dmid[4] = 20;
        if (kind == 1) dmid[4] = -20;
        build_from_diffs();
    endtask

    task automatic drive(int row, int col, int scale, logic v);
        in_row   = ROW_W'(row);
        in_col   = COL_W'(col);
        in_scale = SCALE_W'(scale);
        in_valid = v;
    endtask

    // one window in, result sampled at the negedge after the second edge
    task automatic run_one(int row, int col, int scale, logic v);
        @(negedge clk);
        drive(row, col, scale, v);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic expect_out(string req, int v, int c, int m);
        chk(req, "out_valid", int'(out_valid), v);
        chk(req, "out_cand", int'(out_cand), c);
        chk(req, "out_is_max", int'(out_is_max), m);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        load_pattern(0);
        drive(0, 0, 0, 1'b1);
        repeat (3) @(negedge clk);
        expect_out("R8 reset", 0, 0, 0);
        in_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        expect_out("R8 after reset", 0, 0, 0);
    endtask

    task automatic t_max();
        load_pattern(0);
        run_one(100, 200, 2, 1'b1);
        expect_out("R3 R1 maximum", 1, 1, 1);
        chk("R7", "out_row", int'(out_row), 100);
        chk("R7", "out_col", int'(out_col), 200);
        chk("R7", "out_scale", int'(out_scale), 2);
    endtask

    task automatic t_min();
        load_pattern(1);
        run_one(7, 4095, 1, 1'b1);
        expect_out("R4 R1 minimum", 1, 1, 0);
        chk("R7", "out_col", int'(out_col), 4095);
    endtask

    task automatic t_ties();
        for (int p = 0; p < 3; p++) begin
            load_pattern(0);
            case (p)
                0: dlo[4] = 20;
                1: dmid[8] = 20;
                default: dhi[0] = 20;
            endcase
            build_from_diffs();
            run_one(1, 1, 1, 1'b1);
            expect_out($sformatf("R5 tie in plane %0d", p), 1, 0, 0);
        end
        load_pattern(2);
        run_one(2, 2, 2, 1'b1);
        expect_out("R5 flat", 1, 0, 0);
    endtask

    task automatic t_one_outlier();
        load_pattern(0);
        dhi[2] = 21;
        build_from_diffs();
        run_one(3, 3, 1, 1'b1);
        expect_out("R6 larger upper neighbour", 1, 0, 0);
        load_pattern(1);
        dlo[6] = -25;
        build_from_diffs();
        run_one(3, 4, 1, 1'b1);
        expect_out("R6 smaller lower neighbour", 1, 0, 0);
        load_pattern(0);
        dmid[0] = 30;
        build_from_diffs();
        run_one(3, 5, 1, 1'b1);
        expect_out("R6 larger middle neighbour", 1, 0, 0);
    endtask

    task automatic t_saturate();
        for (int k = 0; k < 4; k++)
            for (int i = 0; i < NS; i++)
                bw[k][i] = '0;
        bw[1][4] = 16'sh8000;
        bw[2][4] = 16'sh7FFF;
        run_one(9, 9, 3, 1'b1);
        expect_out("R2 positive clamp maximum", 1, 1, 1);
        bw[1][3] = 16'sh8000;
        bw[2][3] = 16'sh7FFF;
        run_one(9, 10, 3, 1'b1);
        expect_out("R2 R5 clamp tie", 1, 0, 0);
        for (int k = 0; k < 4; k++)
            for (int i = 0; i < NS; i++)
                bw[k][i] = '0;
        bw[1][4] = 16'sh7FFF;
        bw[2][4] = 16'sh8000;
        run_one(9, 11, 3, 1'b1);
        expect_out("R2 negative clamp minimum", 1, 1, 0);
    endtask

    task automatic t_stream();
        int exp_c [3] = '{1, 1, 0};
        int exp_m [3] = '{1, 0, 0};
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (k >= 2) begin
                expect_out($sformatf("R7 stream item %0d", k-2), 1, exp_c[k-2], exp_m[k-2]);
                chk("R7", "stream row", int'(out_row), 10 + (k-2));
                chk("R7", "stream col", int'(out_col), 20 + (k-2));
                chk("R7", "stream scale", int'(out_scale), k-1);
            end
            if (k < 3) begin
                load_pattern(k);
                drive(10 + k, 20 + k, k + 1, 1'b1);
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        expect_out("R7 stream drained", 0, 0, 0);
    endtask

    task automatic t_invalid();
        load_pattern(0);
        run_one(5, 5, 1, 1'b0);
        expect_out("R8 invalid input ignored", 0, 0, 0);
    endtask

    initial begin
        t_reset();
        t_max();
        t_min();
        t_ties();
        t_one_outlier();
        t_saturate();
        t_stream();
        t_invalid();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule